// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

This block gathers 64 peripheral-side and 8 processor-local interrupt request lines. Every line is a pure level with no latching. Each line is ANDed with its own enable bit. The results are ORed into a single IRQ output. A separate fast-interrupt (FIQ) output follows one line chosen by software. That line is taken raw, before any enable mask is applied.

Software reaches the block through a plain 32-bit word bus with no handshake. A write is one cycle of `bus_sel_i` and `bus_wr_i` together. Read data is a combinational function of the address and the current state.

Enable masks change only through paired registers:
- A set-style register turns on the enables that have a 1 in the written word.
- A clear-style register turns off the enables that have a 1 in the written word.

A summary word shows, in one read:
- the enabled local sources;
- a flag for each half of the peripheral sources;
- eleven frequently used peripheral sources.

Interrupts are cleared at the source. The controller holds no pending state of its own.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset all enable bits are 0, and the FIQ control word reads 0. With no enables set, `irq_o` and `fiq_o` are 0.
- R2: Writing to a set-style register sets each enable bit that has a 1 in the written word. Bits written as 0 keep their value. The set-style offsets are 0x10 (peripheral 0–31), 0x14 (peripheral 32–63) and 0x18 (local; data bits 7:0 only). A set-style register reads back as the current mask, zero-extended to 32 bits.
- R3: Writing to a clear-style register clears each enable bit that has a 1 in the written word. Bits written as 0 keep their value. The clear-style offsets are 0x1C (peripheral 0–31), 0x20 (peripheral 32–63) and 0x24 (local; data bits 7:0 only).
- R4: A clear-style register reads as the bitwise inverse of its 32-bit zero-extended mask.
- R5: Offset 0x04 reads peripheral levels 0–31 ANDed with their enables. Offset 0x08 does the same for peripheral levels 32–63.
- R6: In the summary word at offset 0x00:
  - bits 7:0 are the local levels ANDed with their enables;
  - bit 8 is the OR of the enabled peripheral sources 0–31;
  - bit 9 is the OR of the enabled peripheral sources 32–63.
- R7: Summary bits 10 to 20 hold, in this order, the enabled peripheral sources 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62. Bits 31:21 read 0.
- R8: `irq_o` is 1 exactly when at least one source, peripheral or local, is both active and enabled.
- R9: The FIQ control word at offset 0x0C holds the source select in bits 6:0 and the FIQ enable in bit 7. A read returns both fields as written.
- R10: With the FIQ enable set, `fiq_o` equals the raw level of the selected line, whatever its enable bit:
  - select 0–63 picks a peripheral line;
  - select 64–71 picks local line (select − 64).
  With the FIQ enable clear, `fiq_o` is 0.
- R11: Select values 72 to 127 drive `fiq_o` to 0.
- R12: Reads of any other offset, including addresses that are not word aligned, return 0. Writes to those offsets change no state.
- R13: A register write changes the outputs starting with the cycle after its strobe edge. `irq_o` and `fiq_o` follow input levels combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_lvl_i | input | 64 | Peripheral interrupt levels |
| local_lvl_i | input | 8 | Processor-local interrupt levels |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Masked interrupt request |
| fiq_o | output | 1 | Fast interrupt request from the selected line |

## Verification
The results fall into two timing classes.
- **Same cycle.** Read data, `irq_o` and `fiq_o` depend only on the current levels, address and stored state. They are therefore due in the same cycle as a level or address change. The bench drives those inputs at the falling edge and samples one nanosecond later, before the next rising edge.
- **Next cycle.** Register writes land at the rising edge of the strobe cycle. Every read-back or output check after a write is therefore taken at a later falling edge. One directed case samples `irq_o` both just before and just after that edge, to confirm the one-cycle delay stated in R13.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int WORD_W    = 32;
  localparam int SEL_W     = 7;
  localparam int MIRROR_N  = 11;
  localparam int MIRROR_LSB = 10;
  localparam int ANY_LO_BIT = 8;
  localparam int ANY_HI_BIT = 9;

  localparam int OFF_SUMMARY = 'h00;
  localparam int OFF_PEND_LO = 'h04;
  localparam int OFF_PEND_HI = 'h08;
  localparam int OFF_FIQ     = 'h0C;
  localparam int OFF_SET_LO  = 'h10;
  localparam int OFF_SET_LOC = 'h18;
  localparam int OFF_CLR_LO  = 'h1C;
  localparam int OFF_CLR_LOC = 'h24;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } fiq_ctrl_t;

  function automatic int mirror_src(input int idx);
    case (idx)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      4: return 19;
      5: return 53;
      6: return 54;
      7: return 55;
      8: return 56;
      9: return 57;
      default: return 62;
    endcase
  endfunction
endpackage

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int N_PERIPH = 64,
  parameter int N_LOCAL  = 8,
  parameter int ADDR_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [N_PERIPH-1:0] en_periph,
  output logic [N_LOCAL-1:0]  en_local,
  output fiq_ctrl_t           fiq_ctrl
);
  localparam int P_WORDS = N_PERIPH / WORD_W;

  // One set/clear pair of enable words per 32 peripheral lines
  for (genvar k = 0; k < P_WORDS; k++) begin : g_word
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(OFF_SET_LO + 4 * k);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(OFF_CLR_LO + 4 * k);
    always_ff @(posedge clk) begin
      if (!rst_n)
        en_periph[k*WORD_W +: WORD_W] <= '0;
      else if (wr_en && wr_addr == SET_A)
        en_periph[k*WORD_W +: WORD_W] <= en_periph[k*WORD_W +: WORD_W] | wr_data;
      else if (wr_en && wr_addr == CLR_A)
        en_periph[k*WORD_W +: WORD_W] <= en_periph[k*WORD_W +: WORD_W] & ~wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      en_local <= '0;
    else if (wr_en && wr_addr == ADDR_W'(OFF_SET_LOC))
      en_local <= en_local | wr_data[N_LOCAL-1:0];
    else if (wr_en && wr_addr == ADDR_W'(OFF_CLR_LOC))
      en_local <= en_local & ~wr_data[N_LOCAL-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      fiq_ctrl <= '0;
    else if (wr_en && wr_addr == ADDR_W'(OFF_FIQ))
      fiq_ctrl <= fiq_ctrl_t'(wr_data[SEL_W:0]);
  end
endmodule

// File: rtl/lirq_pend.sv
module lirq_pend
  import lirq_pkg::*;
#(
  parameter int N_PERIPH = 64,
  parameter int N_LOCAL  = 8
) (
  input  logic [N_PERIPH-1:0] lvl_periph,
  input  logic [N_LOCAL-1:0]  lvl_local,
  input  logic [N_PERIPH-1:0] en_periph,
  input  logic [N_LOCAL-1:0]  en_local,
  output logic [N_PERIPH-1:0] pend_periph,
  output logic [WORD_W-1:0]   summary,
  output logic                irq
);
  localparam int HALF = N_PERIPH / 2;

  logic [N_LOCAL-1:0]  pend_local;
  logic [MIRROR_N-1:0] mirror;

  assign pend_periph = lvl_periph & en_periph;
  assign pend_local  = lvl_local & en_local;
  assign irq         = (|pend_periph) | (|pend_local);

  for (genvar g = 0; g < MIRROR_N; g++) begin : g_mirror
    localparam int SRC = mirror_src(g);
    assign mirror[g] = pend_periph[SRC];
  end

  always_comb begin
    summary                                = '0;
    summary[N_LOCAL-1:0]                   = pend_local;
    summary[ANY_LO_BIT]                    = |pend_periph[HALF-1:0];
    summary[ANY_HI_BIT]                    = |pend_periph[N_PERIPH-1:HALF];
    summary[MIRROR_LSB +: MIRROR_N]        = mirror;
  end
endmodule

// File: rtl/lirq_fiq.sv
module lirq_fiq
  import lirq_pkg::*;
#(
  parameter int N_PERIPH = 64,
  parameter int N_LOCAL  = 8
) (
  input  logic [N_PERIPH-1:0] lvl_periph,
  input  logic [N_LOCAL-1:0]  lvl_local,
  input  fiq_ctrl_t           fiq_ctrl,
  output logic                fiq
);
  localparam int N_ALL = N_PERIPH + N_LOCAL;

  // Local lines sit directly above the peripheral lines in select space
  logic [N_ALL-1:0] all_lvl;
  assign all_lvl = {lvl_local, lvl_periph};

  always_comb begin
    fiq = 1'b0;
    if (fiq_ctrl.en && int'(fiq_ctrl.sel) < N_ALL)
      fiq = all_lvl[fiq_ctrl.sel];
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lirq_pkg::*;
#(
  parameter int N_PERIPH = 64,
  parameter int N_LOCAL  = 8,
  parameter int ADDR_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PERIPH-1:0] periph_lvl_i,
  input  logic [N_LOCAL-1:0]  local_lvl_i,
  input  logic                bus_sel_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic                irq_o,
  output logic                fiq_o
);
  localparam int P_WORDS = N_PERIPH / WORD_W;
  localparam int PAD_LOC = WORD_W - N_LOCAL;

  logic [N_PERIPH-1:0] en_periph;
  logic [N_LOCAL-1:0]  en_local;
  fiq_ctrl_t           fiq_ctrl;
  logic [N_PERIPH-1:0] pend_periph;
  logic [WORD_W-1:0]   summary;
  logic [WORD_W-1:0]   loc_word;

  lirq_regs #(.N_PERIPH(N_PERIPH), .N_LOCAL(N_LOCAL), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_sel_i & bus_wr_i),
    .wr_addr  (bus_addr_i),
    .wr_data  (bus_wdata_i),
    .en_periph(en_periph),
    .en_local (en_local),
    .fiq_ctrl (fiq_ctrl)
  );

  lirq_pend #(.N_PERIPH(N_PERIPH), .N_LOCAL(N_LOCAL)) u_pend (
    .lvl_periph (periph_lvl_i),
    .lvl_local  (local_lvl_i),
    .en_periph  (en_periph),
    .en_local   (en_local),
    .pend_periph(pend_periph),
    .summary    (summary),
    .irq        (irq_o)
  );

  lirq_fiq #(.N_PERIPH(N_PERIPH), .N_LOCAL(N_LOCAL)) u_fiq (
    .lvl_periph(periph_lvl_i),
    .lvl_local (local_lvl_i),
    .fiq_ctrl  (fiq_ctrl),
    .fiq       (fiq_o)
  );

  assign loc_word = {{PAD_LOC{1'b0}}, en_local};

  // Read decode: pure function of address and state
  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFF_SUMMARY))
      bus_rdata_o = summary;
    else if (bus_addr_i == ADDR_W'(OFF_FIQ))
      bus_rdata_o = {{(WORD_W-SEL_W-1){1'b0}}, fiq_ctrl};
    else if (bus_addr_i == ADDR_W'(OFF_SET_LOC))
      bus_rdata_o = loc_word;
    else if (bus_addr_i == ADDR_W'(OFF_CLR_LOC))
      bus_rdata_o = ~loc_word;
    else
      for (int k = 0; k < P_WORDS; k++) begin
        if (bus_addr_i == ADDR_W'(OFF_PEND_LO + 4 * k))
          bus_rdata_o = pend_periph[k*WORD_W +: WORD_W];
        if (bus_addr_i == ADDR_W'(OFF_SET_LO + 4 * k))
          bus_rdata_o = en_periph[k*WORD_W +: WORD_W];
        if (bus_addr_i == ADDR_W'(OFF_CLR_LO + 4 * k))
          bus_rdata_o = ~en_periph[k*WORD_W +: WORD_W];
      end
  end
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker
  import lirq_pkg::*;
#(
  parameter int N_PERIPH = 64,
  parameter int N_LOCAL  = 8,
  parameter int ADDR_W   = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel_i,
  input logic                bus_wr_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [31:0]         bus_rdata_o,
  input logic                irq_o,
  input logic                fiq_o,
  input logic [N_PERIPH-1:0] en_periph,
  input logic [N_LOCAL-1:0]  en_local,
  input fiq_ctrl_t           fiq_ctrl
);
  logic wr_stb;
  logic unmapped;
  assign wr_stb   = bus_sel_i & bus_wr_i;
  assign unmapped = (bus_addr_i[1:0] != 2'b00) || (int'(bus_addr_i) > OFF_CLR_LOC);

  AST_FIQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_ctrl.en |-> !fiq_o); // R10

  AST_FIQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fiq_ctrl.sel) >= N_PERIPH + N_LOCAL |-> !fiq_o); // R11

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_periph == '0 && en_local == '0) |-> !irq_o); // R8

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(en_periph) && $stable(en_local) && $stable(fiq_ctrl))); // R13

  AST_SET_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && bus_addr_i == ADDR_W'(OFF_SET_LO))
      |=> (($past(en_periph[31:0]) & ~en_periph[31:0]) == 32'h0)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && !bus_wr_i && unmapped) |-> bus_rdata_o == 32'h0); // R12
endmodule

bind lvl_irq_ctrl lirq_checker #(.N_PERIPH(N_PERIPH), .N_LOCAL(N_LOCAL), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel_i  (bus_sel_i),
  .bus_wr_i   (bus_wr_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .en_periph  (en_periph),
  .en_local   (en_local),
  .fiq_ctrl   (fiq_ctrl)
);

// File: tb/test_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module test_lvl_irq_ctrl;
  localparam logic [8:0] A_SUM = 9'h00, A_PLO = 9'h04, A_PHI = 9'h08, A_FIQ = 9'h0C;
  localparam logic [8:0] A_SLO = 9'h10, A_SHI = 9'h14, A_SLOC = 9'h18;
  localparam logic [8:0] A_CLO = 9'h1C, A_CHI = 9'h20, A_CLOC = 9'h24;

  // {periph[63:0], local[7:0], irq, summary[31:0]} with every enable set
  localparam int NV = 9;
  localparam logic [104:0] VEC [NV] = '{
    {64'h0, 8'h00, 1'b0, 32'h0000_0000},
    {64'h0000_0000_0000_0080, 8'h00, 1'b1, 32'h0000_0500},
    {64'h4000_0000_0000_0000, 8'h00, 1'b1, 32'h0010_0200},
    {64'h0, 8'h81, 1'b1, 32'h0000_0081},
    {64'h0000_0000_0000_0001, 8'h00, 1'b1, 32'h0000_0100},
    {64'h0020_0000_0000_0000, 8'h00, 1'b1, 32'h0000_8200},
    {64'h0000_0000_0008_0000, 8'h00, 1'b1, 32'h0000_4100},
    {64'h8000_0000_0000_0000, 8'h00, 1'b1, 32'h0000_0200},
    {64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b1, 32'h001F_FFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] periph_lvl = '0;
  logic [7:0]  local_lvl = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, fiq;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  lvl_irq_ctrl i_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .periph_lvl_i(periph_lvl), .local_lvl_i(local_lvl),
    .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic lvl_chk(input string req, input logic [63:0] p, input logic [7:0] l,
                         input logic exp_irq, input logic exp_fiq);
    @(negedge clk);
    periph_lvl = p; local_lvl = l;
    #1;
    chk({req, " irq"}, {31'b0, irq}, {31'b0, exp_irq});
    chk({req, " fiq"}, {31'b0, fiq}, {31'b0, exp_fiq});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R13 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R4: reset state
    rd_chk("R1 set-lo", A_SLO, 32'h0);
    rd_chk("R1 set-loc", A_SLOC, 32'h0);
    rd_chk("R1 fiq ctrl", A_FIQ, 32'h0);
    rd_chk("R4 clr-hi", A_CHI, 32'hFFFF_FFFF);
    rd_chk("R4 clr-loc", A_CLOC, 32'hFFFF_FFFF);
    lvl_chk("R1", 64'h0, 8'h0, 1'b0, 1'b0);

    // R13: write takes effect only after its strobe edge; R8 masking
    lvl_chk("R8 masked", 64'h0000_0100_0000_0000, 8'h0, 1'b0, 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_SHI; bus_wdata = 32'h0000_0100;
    #1 chk("R13 before edge", {31'b0, irq}, 32'h0);
    @(posedge clk); #1 chk("R13 after edge", {31'b0, irq}, 32'h1);
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    wr(A_CHI, 32'h0000_0100);
    lvl_chk("R8 cleared", 64'h0000_0100_0000_0000, 8'h0, 1'b0, 1'b0);

    // R2 / R3 / R4 / R5
    wr(A_SLO, 32'h0000_00F0);
    wr(A_SLO, 32'h0000_000F);
    rd_chk("R2 set keeps zeros", A_SLO, 32'h0000_00FF);
    wr(A_SLOC, 32'h0000_01FF);
    rd_chk("R2 local low byte", A_SLOC, 32'h0000_00FF);
    wr(A_CLO, 32'h0000_0030);
    rd_chk("R3 clear", A_SLO, 32'h0000_00CF);
    rd_chk("R4 inverse", A_CLO, 32'hFFFF_FF30);
    wr(A_CLOC, 32'h0000_000F);
    rd_chk("R3 local clear", A_SLOC, 32'h0000_00F0);
    @(negedge clk) periph_lvl = 64'h0000_0001_0000_00FF;
    rd_chk("R5 pending lo", A_PLO, 32'h0000_00CF);
    rd_chk("R5 pending hi", A_PHI, 32'h0);

    // R6 / R7 / R8: summary table with all enables on
    wr(A_SLO, 32'hFFFF_FFFF);
    wr(A_SHI, 32'hFFFF_FFFF);
    wr(A_SLOC, 32'hFFFF_FFFF);
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      periph_lvl = VEC[v][104:41]; local_lvl = VEC[v][40:33];
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_SUM;
      #1;
      chk($sformatf("R6/R7 summary vec %0d", v), bus_rdata, VEC[v][31:0]);
      chk($sformatf("R8 irq vec %0d", v), {31'b0, irq}, {31'b0, VEC[v][32]});
    end

    // R9 / R10 / R11: FIQ selection, unmasked
    wr(A_CLO, 32'h0F0F_0F0F);
    wr(A_FIQ, 32'h0000_0081);
    rd_chk("R9 fiq readback", A_FIQ, 32'h0000_0081);
    lvl_chk("R10 raw unmasked", 64'h2, 8'h0, 1'b0, 1'b1);
    lvl_chk("R10 low level", 64'h0, 8'h0, 1'b0, 1'b0);
    wr(A_FIQ, 32'h0000_00C3);
    lvl_chk("R10 local pick", 64'h0, 8'h08, 1'b1, 1'b1);
    lvl_chk("R10 other local", 64'h0, 8'h04, 1'b1, 1'b0);
    wr(A_FIQ, 32'h0000_0043);
    rd_chk("R9 enable clear", A_FIQ, 32'h0000_0043);
    lvl_chk("R10 disabled", 64'h0, 8'h08, 1'b1, 1'b0);
    wr(A_FIQ, 32'h0000_00C8);
    lvl_chk("R11 sel 72", 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b1, 1'b0);
    wr(A_FIQ, 32'h0000_00FF);
    lvl_chk("R11 sel 127", 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b1, 1'b0);

    // R12: unmapped offsets
    wr(A_FIQ, 32'h0000_0085);
    wr(9'h028, 32'hFFFF_FFFF);
    wr(9'h011, 32'hFFFF_FFFF);
    wr(9'h1FC, 32'hFFFF_FFFF);
    rd_chk("R12 read 0x28", 9'h028, 32'h0);
    rd_chk("R12 read unaligned", 9'h012, 32'h0);
    rd_chk("R12 enable untouched", A_SLO, 32'hF0F0_F0F0);
    rd_chk("R12 fiq untouched", A_FIQ, 32'h0000_0085);

    // R1: mid-run reset clears state
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd_chk("R1 reset enable", A_SHI, 32'h0);
    rd_chk("R1 reset fiq", A_FIQ, 32'h0);
    lvl_chk("R1 reset outputs", 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule